// File: doc/BRIEF.md
# Tuning and Temperature Register Port over I2C

This block is a two-wire serial target that gives a host access to four byte-wide registers. Two of them hold a signed frequency-tuning word and a flag that freezes temperature compensation. The other two are read-only and present a 12-bit temperature value. The serial clock and data lines are sampled with the system clock. Each line passes through a synchronizer and a short majority filter. START, STOP and repeated START are then recovered from the filtered lines. Towards the pad, the block drives a single open-drain pull-down enable.

A write transfer carries the target address, a register index and any number of data bytes. The index pointer advances after each byte. A read transfer starts at the stored pointer and keeps returning bytes until the host answers with a not-acknowledge. The live temperature input is copied into the user-visible temperature pair at one point only: when an addressed write delivers its register index. A following multi-byte read therefore always returns a high and low part taken from the same sample. The tuning word, the freeze flag and a one-cycle strobe on every tuning write leave the block as plain outputs.

Top module: `tcxo_i2c_regs`

## Requirements
- R1: After reset, sda_oe is 0, tune_word is 0 and dcomp is 0, the register pointer is 0, and registers 2 and 3 read 19h and 00h (the +25 °C code 190h).
- R2: A byte whose upper seven bits equal 1000001 is acknowledged (SDA held low during the ninth clock), with bit 0 selecting write (0, byte 82h) or read (1, byte 83h). Any other address gets no acknowledge, and nothing in the rest of that transfer is acknowledged or written.
- R3: In a write, the byte after the address loads the pointer from its low two bits. Each later data byte is acknowledged and stored at the pointer, and the pointer then increments. Register 0 bit 7 drives dcomp, register 0 bits 6..0 drive tune_word[14:8], and register 1 drives tune_word[7:0].
- R4: A read returns bytes MSB first, starting at the current pointer, and the pointer increments after each byte. A read that follows no index write uses the pointer left by the last access.
- R5: The target sends another byte after each host acknowledge. After a host not-acknowledge it keeps SDA released, so the next clock pulse reads 1.
- R6: Receiving the register index in an addressed write copies temp_live[11:4] into register 2 and {temp_live[3:0],0000} into register 3. No other event changes these registers.
- R7: The pointer wraps from 3 to 0. Data bytes written to registers 2 or 3 are acknowledged but leave their contents unchanged.
- R8: tune_upd pulses high for exactly one clock for each data byte written to register 0 or 1. It does not pulse for the index byte or for writes to registers 2 and 3.
- R9: A repeated START, at any point, restarts address reception without the bus going idle.
- R10: An SDA pulse lasting one system clock while SCL is high is rejected by the majority filter. It is not taken as START or STOP, and the byte in progress is received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| temp_live | input | 12 | Current temperature code, 0.0625 °C per LSB |
| sda_oe | output | 1 | 1 pulls the data line low |
| tune_word | output | 15 | Two's-complement tuning value {reg0[6:0], reg1} |
| dcomp | output | 1 | Compensation freeze flag, reg0 bit 7 |
| tune_upd | output | 1 | One-cycle strobe after a tuning register write |

## Verification
The bench builds the block with its default parameters: target address 41h, a 12-bit temperature resetting to 190h, a two-stage synchronizer and the three-tap majority filter. The majority variant is what makes the single-clock SDA glitch of R10 a meaningful case. With the passthrough variant that glitch would abort the transfer. The 12-bit width puts the nibble split of register 3 and the 190h reset code within reach of direct byte comparisons. The four-entry map lets a short read run past register 3 and return to register 0.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int REG_W  = 8;
   localparam int NREGS  = 4;
   localparam int PTR_W  = $clog2(NREGS);
   localparam int TUNE_W = 2 * REG_W - 1;
   localparam int BIT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } i2cr_state_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_INDEX,
      PH_DATA
   } i2cr_phase_e;
endpackage

// File: rtl/i2cr_filt.sv
module i2cr_filt #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_TAPS != 1 && FILT_TAPS != 3) begin : g_bad_taps
      $error("FILT_TAPS must be 1 or 3");
   end

   logic [SYNC_STAGES-1:0] sy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '1;
      else        sy <= {sy[SYNC_STAGES-2:0], d};
   end

   if (FILT_TAPS == 3) begin : g_major
      logic [2:0] win;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win <= '1;
            q   <= 1'b1;
         end else begin
            win <= {win[1:0], sy[SYNC_STAGES-1]};
            q   <= (win[0] & win[1]) | (win[1] & win[2]) | (win[0] & win[2]);
         end
      end
   end else begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b1;
         else        q <= sy[SYNC_STAGES-1];
      end
   end
endmodule

// File: rtl/i2cr_cond.sv
module i2cr_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic start,
   output logic stop,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign start    = scl_f & scl_d & sda_d & ~sda_f;
   assign stop     = scl_f & scl_d & ~sda_d & sda_f;
   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile import i2cr_pkg::*; #(
   parameter int          TEMP_W   = 12,
   parameter int unsigned TEMP_RST = 'h190
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              snap,
   input  logic [TEMP_W-1:0] temp_live,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic [TUNE_W-1:0] tune_word,
   output logic              dcomp,
   output logic              tune_upd,
   output logic [REG_W-1:0]  treg_hi
);
   localparam logic [15:0] RST_EXT = 16'(TEMP_RST) << (16 - TEMP_W);

   logic [REG_W-1:0] tune_hi, tune_lo, treg_lo;
   logic [15:0]      live_ext;

   assign live_ext = 16'(temp_live) << (16 - TEMP_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tune_hi  <= '0;
         tune_lo  <= '0;
         treg_hi  <= RST_EXT[15:8];
         treg_lo  <= RST_EXT[7:0];
         tune_upd <= 1'b0;
      end else begin
         tune_upd <= 1'b0;
         if (wr_en && wr_addr == PTR_W'(0)) begin
            tune_hi  <= wr_data;
            tune_upd <= 1'b1;
         end
         if (wr_en && wr_addr == PTR_W'(1)) begin
            tune_lo  <= wr_data;
            tune_upd <= 1'b1;
         end
         if (snap) begin
            treg_hi <= live_ext[15:8];
            treg_lo <= live_ext[7:0];
         end
      end
   end

   always_comb begin
      case (rd_addr)
         PTR_W'(0): rd_data = tune_hi;
         PTR_W'(1): rd_data = tune_lo;
         PTR_W'(2): rd_data = treg_hi;
         default:   rd_data = treg_lo;
      endcase
   end

   assign tune_word = {tune_hi[REG_W-2:0], tune_lo};
   assign dcomp     = tune_hi[REG_W-1];
endmodule

// File: rtl/tcxo_i2c_regs.sv
module tcxo_i2c_regs import i2cr_pkg::*; #(
   parameter logic [6:0]  SLAVE_ADDR  = 7'b1000001,
   parameter int          TEMP_W      = 12,
   parameter int unsigned TEMP_RST    = 'h190,
   parameter int          SYNC_STAGES = 2,
   parameter int          FILT_TAPS   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [TEMP_W-1:0] temp_live,
   output logic              sda_oe,
   output logic [TUNE_W-1:0] tune_word,
   output logic              dcomp,
   output logic              tune_upd
);
   if (TEMP_W < 9 || TEMP_W > 16) begin : g_bad_tw
      $error("TEMP_W must lie in 9..16");
   end
   if (TEMP_RST >= (1 << TEMP_W)) begin : g_bad_rst
      $error("TEMP_RST does not fit TEMP_W");
   end

   logic [1:0] raw, filt;
   logic       scl_f, sda_f, start, stop, scl_rise, scl_fall;

   assign raw = {sda_i, scl_i};

   for (genvar i = 0; i < 2; i++) begin : g_line
      i2cr_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_filt (
         .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(filt[i]));
   end
   assign scl_f = filt[0];
   assign sda_f = filt[1];

   i2cr_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall));

   i2cr_state_e      st;
   i2cr_phase_e      ph;
   logic [BIT_W-1:0] bitcnt;
   logic [REG_W-1:0] sh, rd_data, treg_hi;
   logic [PTR_W-1:0] ptr;
   logic             rw, nack, byte_in, wr_en, snap;

   assign byte_in = (st == ST_RX) && scl_fall && (bitcnt == BIT_W'(REG_W));
   assign wr_en   = byte_in && (ph == PH_DATA);
   assign snap    = byte_in && (ph == PH_INDEX);

   i2cr_regfile #(.TEMP_W(TEMP_W), .TEMP_RST(TEMP_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(sh),
      .snap(snap), .temp_live(temp_live), .rd_addr(ptr), .rd_data(rd_data),
      .tune_word(tune_word), .dcomp(dcomp), .tune_upd(tune_upd), .treg_hi(treg_hi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph     <= PH_ADDR;
         bitcnt <= '0;
         sh     <= '0;
         ptr    <= '0;
         rw     <= 1'b0;
         nack   <= 1'b0;
         sda_oe <= 1'b0;
      end else if (start) begin
         st     <= ST_RX;
         ph     <= PH_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (stop) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         case (st)
            ST_RX: begin
               if (scl_rise) begin
                  sh     <= {sh[REG_W-2:0], sda_f};
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_in) begin
                  bitcnt <= '0;
                  case (ph)
                     PH_ADDR: begin
                        if (sh[REG_W-1:1] == SLAVE_ADDR) begin
                           rw     <= sh[0];
                           st     <= ST_ACK;
                           sda_oe <= 1'b1;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end
                     PH_INDEX: begin
                        ptr    <= sh[PTR_W-1:0];
                        st     <= ST_ACK;
                        sda_oe <= 1'b1;
                     end
                     default: begin
                        ptr    <= ptr + 1'b1;
                        st     <= ST_ACK;
                        sda_oe <= 1'b1;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (ph == PH_ADDR && rw) begin
                     sh     <= rd_data;
                     sda_oe <= ~rd_data[REG_W-1];
                     st     <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= ST_RX;
                     ph     <= (ph == PH_ADDR) ? PH_INDEX : PH_DATA;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == BIT_W'(REG_W - 1)) begin
                     sda_oe <= 1'b0;
                     st     <= ST_MACK;
                     ptr    <= ptr + 1'b1;
                  end else begin
                     sh     <= {sh[REG_W-2:0], 1'b0};
                     sda_oe <= ~sh[REG_W-2];
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  nack <= sda_f;
               end else if (scl_fall) begin
                  if (!nack) begin
                     sh     <= rd_data;
                     sda_oe <= ~rd_data[REG_W-1];
                     bitcnt <= '0;
                     st     <= ST_TX;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk import i2cr_pkg::*; (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_f,
   input logic              sda_oe,
   input logic              tune_upd,
   input logic [TUNE_W-1:0] tune_word,
   input logic              dcomp,
   input logic              idle,
   input logic              snap,
   input logic [REG_W-1:0]  treg_hi
);
   // R5: the pull-down only changes while the filtered clock is low
   p_oe_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_f);

   // R5: an idle target never drives the line
   p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !sda_oe);

   // R8: the strobe lasts a single cycle
   p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tune_upd |=> !tune_upd);

   // R3: tuning outputs move only together with the strobe
   p_tune_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(tune_word) && $stable(dcomp)) |-> tune_upd);

   // R6: temperature high byte changes only after a snapshot request
   p_temp_snap_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(treg_hi) |-> $past(snap));
endmodule

bind tcxo_i2c_regs i2cr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
   .tune_upd(tune_upd), .tune_word(tune_word), .dcomp(dcomp),
   .idle(st == i2cr_pkg::ST_IDLE), .snap(snap), .treg_hi(treg_hi));

// File: tb/tb_tcxo_i2c_regs.sv
module tb_tcxo_i2c_regs;
   localparam int Q = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic [11:0] temp_live = 12'h7A3;
   logic        sda_oe, dcomp, tune_upd;
   logic [14:0] tune_word;
   logic        sda_line;
   int          checks = 0, errors = 0, upd_cnt = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   tcxo_i2c_regs dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .temp_live(temp_live), .sda_oe(sda_oe), .tune_word(tune_word),
      .dcomp(dcomp), .tune_upd(tune_upd));

   always @(negedge clk) if (tune_upd) upd_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n = 1);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; scl = 1'b1; wq();
      sda_m = 1'b0; wq(2);
      scl = 1'b0; wq();
   endtask

   task automatic bus_rstart;
      sda_m = 1'b1; wq();
      scl = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl = 1'b0; wq();
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wq();
      scl = 1'b1; wq();
      sda_m = 1'b1; wq(2);
   endtask

   task automatic put_bit(input logic b, input bit glitch, output logic s);
      sda_m = b; wq();
      scl = 1'b1; wq();
      if (glitch) begin
         sda_m = 1'b0; @(negedge clk);
         sda_m = b;
      end
      s = sda_line;
      wq();
      scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input int gbit, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) put_bit(b[i], i == gbit, s);
      put_bit(1'b1, 1'b0, s);
      ack = !s;
   endtask

   task automatic recv_byte(input logic last, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         put_bit(1'b1, 1'b0, s);
         v[i] = s;
      end
      put_bit(last, 1'b0, s);
   endtask

   task automatic t_reset_read;
      logic [7:0] v;
      bit a;
      chk("R1 sda_oe after reset", sda_oe, 0);
      chk("R1 tune_word after reset", tune_word, 0);
      chk("R1 dcomp after reset", dcomp, 0);
      bus_start;
      send_byte(8'h83, -1, a);
      chk("R2 read address acked", a, 1);
      recv_byte(1'b0, v); chk("R4 reg0 at reset pointer", v, 8'h00);
      recv_byte(1'b0, v); chk("R4 reg1", v, 8'h00);
      recv_byte(1'b0, v); chk("R1 reg2 reset temp", v, 8'h19);
      recv_byte(1'b1, v); chk("R1 reg3 reset temp", v, 8'h00);
      bus_stop;
   endtask

   task automatic t_write_tune;
      bit a;
      int u0 = upd_cnt;
      bus_start;
      send_byte(8'h82, -1, a); chk("R2 write address acked", a, 1);
      send_byte(8'h00, -1, a); chk("R3 index acked", a, 1);
      send_byte(8'hC5, -1, a); chk("R3 data0 acked", a, 1);
      send_byte(8'h3C, -1, a); chk("R3 data1 acked", a, 1);
      bus_stop;
      chk("R3 tune_word", tune_word, 15'h453C);
      chk("R3 dcomp", dcomp, 1);
      chk("R8 two strobes", upd_cnt - u0, 2);
   endtask

   task automatic t_snapshot;
      logic [7:0] v;
      logic s;
      bit a;
      int u0 = upd_cnt;
      bus_start;
      send_byte(8'h82, -1, a);
      send_byte(8'h02, -1, a);
      bus_stop;
      chk("R8 no strobe for index", upd_cnt - u0, 0);
      temp_live = 12'h123;
      wq(2);
      bus_start;
      send_byte(8'h83, -1, a);
      recv_byte(1'b0, v); chk("R6 snapshot high", v, 8'h7A);
      recv_byte(1'b0, v); chk("R6 snapshot low", v, 8'h30);
      recv_byte(1'b1, v); chk("R7 wrap to reg0", v, 8'hC5);
      put_bit(1'b1, 1'b0, s);
      chk("R5 released after NACK", s, 1);
      bus_stop;
   endtask

   task automatic t_bad_addr;
      bit a;
      int u0 = upd_cnt;
      bus_start;
      send_byte(8'h84, -1, a); chk("R2 foreign address not acked", a, 0);
      send_byte(8'h00, -1, a); chk("R2 following byte not acked", a, 0);
      send_byte(8'h00, -1, a);
      bus_stop;
      chk("R2 tune unchanged", tune_word, 15'h453C);
      chk("R2 no strobe", upd_cnt - u0, 0);
   endtask

   task automatic t_ro_write;
      logic [7:0] v;
      bit a;
      int u0 = upd_cnt;
      bus_start;
      send_byte(8'h82, -1, a);
      send_byte(8'h03, -1, a);
      send_byte(8'hAA, -1, a); chk("R7 read-only write acked", a, 1);
      send_byte(8'h11, -1, a); chk("R7 wrapped write acked", a, 1);
      bus_stop;
      chk("R7 wrapped write to reg0", tune_word, 15'h113C);
      chk("R7 dcomp cleared", dcomp, 0);
      chk("R8 strobe only for reg0", upd_cnt - u0, 1);
      bus_start;
      send_byte(8'h82, -1, a);
      send_byte(8'h03, -1, a);
      bus_rstart;
      send_byte(8'h83, -1, a);
      recv_byte(1'b0, v); chk("R7 reg3 not written", v, 8'h30);
      recv_byte(1'b1, v); chk("R7 wrap read reg0", v, 8'h11);
      bus_stop;
   endtask

   task automatic t_rstart;
      logic [7:0] v;
      bit a;
      bus_start;
      send_byte(8'h82, -1, a);
      send_byte(8'h01, -1, a);
      bus_rstart;
      send_byte(8'h83, -1, a); chk("R9 address after repeated START", a, 1);
      recv_byte(1'b1, v); chk("R9 read after repeated START", v, 8'h3C);
      bus_stop;
   endtask

   task automatic t_glitch;
      bit a;
      int u0 = upd_cnt;
      bus_start;
      send_byte(8'h82, -1, a);
      send_byte(8'h01, -1, a);
      send_byte(8'hFF, 4, a); chk("R10 glitched byte acked", a, 1);
      bus_stop;
      chk("R10 glitched byte stored", tune_word, 15'h11FF);
      chk("R10 strobe", upd_cnt - u0, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wq(2);
      t_reset_read;
      t_write_tune;
      t_snapshot;
      t_bad_addr;
      t_ro_write;
      t_rstart;
      t_glitch;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule